// File: doc/BRIEF.md
# Bit-Clocked Transmit/Receive Data Path

This block connects a radio transceiver's data bit clock to a pair of bit FIFOs. The incoming bit clock passes through a synchroniser. After that, only true level changes count as clock events, so a repeated sample of the same level does nothing. While transmitting, the block drives one bit from the transmit FIFO on every low-going clock event. While receiving, and when duplex operation is off, it samples the receive pin on every high-going clock event and pushes the bit into the receive FIFO.

The block also times the latch pulse that commits a mode word already loaded into the transceiver. A transmit request sets the transmit state straight away. The latch pulse fires on the first low-going event after that, and the odd/even bit tracker is set so that the next transmitted bit counts as odd. A receive request is served only on a low-going event that completes an even bit. The latch pulse then waits a programmable quarter-bit delay. When it fires, the data line is forced low and the block returns to receive. Clock events that arrive during that wait are dropped. An event counter advances on every accepted event. It serves as the shared time base for the watchdog and mode timers.

Top module: `bitclk_txrx_path`

## Requirements
- R1: Under reset, txd_out, latch_out, tx_active and req_ack are 0 and evt_count is 0.
- R2: While started is 0, no clock event is accepted: no FIFO push or pop, and evt_count holds. Once started, a sampled clock level equal to the last recorded level is not an event.
- R3: While tx_active is 1, each low-going clock event pops one bit and drives it on txd_out. An empty transmit FIFO drives 0 and pops nothing. Receive pushes never happen in transmit.
- R4: While tx_active is 0 and duplex is 0, each high-going clock event pushes the synchronised receive pin value into the receive FIFO. The first event after started rises is accepted whatever the level.
- R5: While duplex is 1, high-going events push nothing.
- R6: After a req_tx pulse, tx_active is 1 from the next cycle. On the first low-going event, latch_out is high for exactly PULSE_W cycles, starting in the same cycle that the transmitted bit appears, and req_ack pulses for one cycle as the latch rises.
- R7: After a TX entry, transmitted bits alternate odd, even, odd, and the first one counts as odd. A pending receive request is served only on a low-going event that carries an even bit. On an odd-bit event nothing happens.
- R8: On a serving event, latch_out rises QDELAY cycles after the cycle in which that event's bit appears. In the cycle the latch rises, tx_active drops to 0, txd_out goes to 0 and req_ack pulses. The latch lasts PULSE_W cycles.
- R9: Clock level changes that arrive while a latch delay or latch pulse is in progress are dropped. They cause no push and do not advance evt_count, but they do update the recorded level.
- R10: evt_count increases by one for each accepted clock event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| started | input | 1 | Enables event processing |
| duplex | input | 1 | Disables receive sampling on this path |
| bclk_in | input | 1 | Transceiver bit clock (asynchronous) |
| rxd_in | input | 1 | Receive data pin (asynchronous) |
| req_tx | input | 1 | One-cycle request to enter transmit |
| req_rx | input | 1 | One-cycle request to return to receive |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no bit |
| tx_fifo_bit | input | 1 | Head bit of the transmit FIFO |
| tx_fifo_pop | output | 1 | Pops the transmit FIFO head |
| rx_fifo_push | output | 1 | Pushes rx_fifo_bit into the receive FIFO |
| rx_fifo_bit | output | 1 | Sampled receive bit |
| txd_out | output | 1 | Transmit data pin |
| latch_out | output | 1 | Mode-word latch pulse |
| tx_active | output | 1 | Current transmit state |
| req_ack | output | 1 | One-cycle pulse when a request is committed |
| evt_count | output | CNT_W | Free-running accepted-event counter |

## Verification
The critical overlap is a bit-clock level change that arrives while the quarter-bit wait for a receive switch is still counting. Two functions then compete in the same cycle window: event acceptance and the pending latch commit. The bench flips the bit clock high in the middle of the wait. It then checks that no receive push appears, that the event counter moved by only the one serving event, and that the latch still rises exactly QDELAY cycles after the even-bit event. A second overlap, the transmit bit drive and the TX-entry latch rising on the same event, is judged by checking that the first latch-high cycle is the one in which the bit appears.

// File: rtl/bctp_pkg.sv
package bctp_pkg;
   typedef enum logic [1:0] {
      LT_IDLE  = 2'd0,
      LT_WAIT  = 2'd1,
      LT_PULSE = 2'd2
   } latch_st_e;
endpackage

// File: rtl/bctp_level_sync.sv
module bctp_level_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bctp_event_detect.sv
module bctp_event_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic started,
   input  logic hold,
   input  logic lvl,
   output logic ev_any,
   output logic ev_rise,
   output logic ev_fall
);
   logic last_q, seen_q, change;

   assign change  = started && (!seen_q || (lvl != last_q));
   assign ev_any  = change && !hold;
   assign ev_rise = ev_any && lvl;
   assign ev_fall = ev_any && !lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (started) begin
         last_q <= lvl;
         seen_q <= 1'b1;
      end
   end

   // R2: nothing is accepted while the path is not started
   assert_quiet_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !ev_any);
endmodule

// File: rtl/bctp_latch_timer.sv
module bctp_latch_timer
   import bctp_pkg::*;
#(
   parameter int PULSE_W = 8,
   parameter int QDELAY  = 1248
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_now,
   input  logic fire_late,
   output logic latch,
   output logic busy,
   output logic commit
);
   localparam int MAXV = (PULSE_W > QDELAY) ? PULSE_W : QDELAY;
   localparam int CW   = $clog2(MAXV + 1);

   latch_st_e     st_q;
   logic [CW-1:0] cnt_q;

   assign latch  = (st_q == LT_PULSE);
   assign busy   = (st_q != LT_IDLE);
   assign commit = (st_q == LT_WAIT) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LT_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            LT_IDLE: begin
               if (fire_now) begin
                  st_q  <= LT_PULSE;
                  cnt_q <= CW'(PULSE_W - 1);
               end else if (fire_late) begin
                  st_q  <= LT_WAIT;
                  cnt_q <= CW'(QDELAY - 1);
               end
            end
            LT_WAIT: begin
               if (cnt_q == '0) begin
                  st_q  <= LT_PULSE;
                  cnt_q <= CW'(PULSE_W - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            LT_PULSE: begin
               if (cnt_q == '0) st_q <= LT_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= LT_IDLE;
         endcase
      end
   end

   // R8: a started delay always ends in a latch pulse
   assert_wait_to_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LT_WAIT) |=> (st_q == LT_WAIT || st_q == LT_PULSE));
   // R6: a latch never begins without passing through a request
   assert_no_spurious_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LT_IDLE && !fire_now) |=> !latch);
endmodule

// File: rtl/bitclk_txrx_path.sv
module bitclk_txrx_path
   import bctp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_W     = 8,
   parameter int QDELAY      = 1248,
   parameter int CNT_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             started,
   input  logic             duplex,
   input  logic             bclk_in,
   input  logic             rxd_in,
   input  logic             req_tx,
   input  logic             req_rx,
   input  logic             tx_fifo_empty,
   input  logic             tx_fifo_bit,
   output logic             tx_fifo_pop,
   output logic             rx_fifo_push,
   output logic             rx_fifo_bit,
   output logic             txd_out,
   output logic             latch_out,
   output logic             tx_active,
   output logic             req_ack,
   output logic [CNT_W-1:0] evt_count
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PULSE_W < 1 || QDELAY < 1) begin : g_bad_timing
         $error("PULSE_W and QDELAY must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic bclk_s, rxd_s;
   logic ev_any, ev_rise, ev_fall;
   logic busy, commit;
   logic tx_q, even_q, pend_tx, pend_rx, txd_q, ack_q;
   logic [CNT_W-1:0] cnt_q;
   logic even_next, entry_now, exit_arm, tx_edge;

   bctp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(bclk_in), .q(bclk_s));
   bctp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_rxd (
      .clk(clk), .rst_n(rst_n), .d(rxd_in), .q(rxd_s));

   bctp_event_detect u_evt (
      .clk(clk), .rst_n(rst_n), .started(started), .hold(busy),
      .lvl(bclk_s), .ev_any(ev_any), .ev_rise(ev_rise), .ev_fall(ev_fall));

   assign tx_edge   = tx_q && ev_fall;
   assign even_next = ~even_q;
   assign entry_now = tx_edge && pend_tx;
   assign exit_arm  = tx_edge && pend_rx && !pend_tx && even_next;

   bctp_latch_timer #(.PULSE_W(PULSE_W), .QDELAY(QDELAY)) u_latch (
      .clk(clk), .rst_n(rst_n), .fire_now(entry_now), .fire_late(exit_arm),
      .latch(latch_out), .busy(busy), .commit(commit));

   assign tx_fifo_pop  = tx_edge && !tx_fifo_empty;
   assign rx_fifo_push = !tx_q && !duplex && ev_rise;
   assign rx_fifo_bit  = rxd_s;
   assign txd_out      = txd_q;
   assign tx_active    = tx_q;
   assign req_ack      = ack_q;
   assign evt_count    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= 1'b0;
         even_q  <= 1'b1;
         pend_tx <= 1'b0;
         pend_rx <= 1'b0;
         txd_q   <= 1'b0;
         ack_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         ack_q <= 1'b0;
         if (ev_any) cnt_q <= cnt_q + 1'b1;
         if (req_tx) begin
            pend_tx <= 1'b1;
            tx_q    <= 1'b1;
         end
         if (req_rx) pend_rx <= 1'b1;
         if (tx_edge) begin
            txd_q  <= tx_fifo_empty ? 1'b0 : tx_fifo_bit;
            even_q <= entry_now ? 1'b1 : even_next;
         end
         if (entry_now) begin
            pend_tx <= 1'b0;
            ack_q   <= 1'b1;
         end
         if (commit) begin
            txd_q   <= 1'b0;
            tx_q    <= 1'b0;
            pend_rx <= 1'b0;
            even_q  <= 1'b0;
            ack_q   <= 1'b1;
         end
      end
   end

   // R4: transmit pops and receive pushes never coincide
   assert_push_pop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_fifo_pop && rx_fifo_push));
   // R6: every acknowledge coincides with a latch pulse
   assert_ack_with_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> latch_out);
   // R8: leaving transmit happens exactly as the latch rises, with the line low
   assert_exit_with_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_q) |-> ($rose(latch_out) && !txd_q));
   // R9: no event is accepted during a latch delay or pulse
   assert_hold_counter_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (cnt_q == $past(cnt_q)));
endmodule

// File: tb/sim_bitclk_txrx_path.sv
`timescale 1ns/1ps
module sim_bitclk_txrx_path;
   localparam int PW = 4;
   localparam int QD = 20;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n, started, duplex, bclk_in, rxd_in, req_tx, req_rx;
   logic tx_fifo_empty, tx_fifo_bit, tx_fifo_pop, rx_fifo_push, rx_fifo_bit;
   logic txd_out, latch_out, tx_active, req_ack;
   logic [CW-1:0] evt_count;

   int checks = 0, errors = 0;
   int pop_n = 0, rx_n = 0, pat_len = 0;
   logic pat [16];
   logic rx_got [16];
   int latch_hi, first_latch, ack_cnt;
   logic txd_at3;

   always #2.5 clk = ~clk;

   bitclk_txrx_path #(.SYNC_STAGES(2), .PULSE_W(PW), .QDELAY(QD), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .started(started), .duplex(duplex),
      .bclk_in(bclk_in), .rxd_in(rxd_in), .req_tx(req_tx), .req_rx(req_rx),
      .tx_fifo_empty(tx_fifo_empty), .tx_fifo_bit(tx_fifo_bit),
      .tx_fifo_pop(tx_fifo_pop), .rx_fifo_push(rx_fifo_push),
      .rx_fifo_bit(rx_fifo_bit), .txd_out(txd_out), .latch_out(latch_out),
      .tx_active(tx_active), .req_ack(req_ack), .evt_count(evt_count));

   assign tx_fifo_empty = (pop_n >= pat_len);
   assign tx_fifo_bit   = (pop_n < 16) ? pat[pop_n] : 1'b0;

   always @(posedge clk) begin
      if (tx_fifo_pop) pop_n <= pop_n + 1;
      if (rx_fifo_push) begin
         rx_got[rx_n % 16] <= rx_fifo_bit;
         rx_n <= rx_n + 1;
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive a new bit-clock level, then observe n falling system-clock edges.
   task automatic drive_bclk(logic v, int n, int flip_at);
      @(negedge clk);
      bclk_in = v;
      latch_hi = 0; first_latch = -1; ack_cnt = 0; txd_at3 = 1'bx;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (latch_out) begin
            latch_hi++;
            if (first_latch < 0) first_latch = i;
         end
         if (req_ack) ack_cnt++;
         if (i == 3) txd_at3 = txd_out;
         if (i == flip_at) bclk_in = ~bclk_in;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; started = 0; duplex = 0; bclk_in = 0; rxd_in = 0;
      req_tx = 0; req_rx = 0;
      repeat (4) @(negedge clk);
      check("R1 txd", int'(txd_out), 0);
      check("R1 latch", int'(latch_out), 0);
      check("R1 tx_active", int'(tx_active), 0);
      check("R1 ack", int'(req_ack), 0);
      check("R1 evt_count", int'(evt_count), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_not_started();
      rxd_in = 1;
      drive_bclk(1, 5, -1);
      drive_bclk(0, 5, -1);
      drive_bclk(1, 5, -1);
      check("R2 no events before start", int'(evt_count), 0);
      check("R2 no pushes before start", rx_n, 0);
   endtask

   task automatic t_rx();
      logic bits [3] = '{1'b0, 1'b1, 1'b1};
      @(negedge clk); started = 1;
      repeat (5) @(negedge clk);
      check("R4 first event pushes", rx_n, 1);
      check("R10 first event counted", int'(evt_count), 1);
      for (int k = 0; k < 3; k++) begin
         rxd_in = bits[k];
         drive_bclk(0, 5, -1);
         drive_bclk(1, 5, -1);
      end
      check("R4 push count", rx_n, 4);
      check("R4 bit0", int'(rx_got[0]), 1);
      check("R4 bit1", int'(rx_got[1]), 0);
      check("R4 bit2", int'(rx_got[2]), 1);
      check("R4 bit3", int'(rx_got[3]), 1);
      drive_bclk(1, 6, -1);
      check("R2 repeated level ignored", int'(evt_count), 7);
      check("R10 event count", int'(evt_count), 7);
   endtask

   task automatic t_duplex();
      duplex = 1; rxd_in = 0;
      drive_bclk(0, 5, -1);
      drive_bclk(1, 5, -1);
      check("R5 duplex no push", rx_n, 4);
      check("R10 duplex events counted", int'(evt_count), 9);
      duplex = 0;
   endtask

   task automatic t_tx_entry();
      pat[0] = 1; pat[1] = 0; pat[2] = 1; pat[3] = 1; pat_len = 4;
      @(negedge clk); req_tx = 1;
      @(negedge clk); req_tx = 0;
      check("R6 tx_active after request", int'(tx_active), 1);
      drive_bclk(0, 12, -1);
      check("R6 latch width", latch_hi, PW);
      check("R6 latch with first bit", first_latch, 3);
      check("R6 ack once", ack_cnt, 1);
      check("R3 entry bit", int'(txd_at3), 1);
      check("R3 pops", pop_n, 1);
   endtask

   task automatic t_tx_bits();
      drive_bclk(1, 5, -1);
      check("R3 no push in tx", rx_n, 4);
      drive_bclk(0, 6, -1);
      check("R3 bit1", int'(txd_at3), 0);
      check("R3 no latch on plain bit", latch_hi, 0);
      drive_bclk(1, 5, -1);
      drive_bclk(0, 6, -1);
      check("R3 bit2", int'(txd_at3), 1);
      check("R3 pops", pop_n, 3);
   endtask

   task automatic t_rx_exit();
      int ev0;
      @(negedge clk); req_rx = 1;
      @(negedge clk); req_rx = 0;
      drive_bclk(1, 5, -1);
      drive_bclk(0, QD + PW + 10, -1);
      check("R7 odd bit no latch", latch_hi, 0);
      check("R7 still in tx", int'(tx_active), 1);
      check("R3 bit3", int'(txd_at3), 1);
      drive_bclk(1, 5, -1);
      ev0 = int'(evt_count);
      drive_bclk(0, QD + PW + 10, 10);
      check("R3 empty fifo drives 0", int'(txd_at3), 0);
      check("R3 empty fifo no pop", pop_n, 4);
      check("R8 latch after quarter delay", first_latch, 3 + QD);
      check("R8 latch width", latch_hi, PW);
      check("R8 ack", ack_cnt, 1);
      check("R8 tx cleared", int'(tx_active), 0);
      check("R8 txd low", int'(txd_out), 0);
      check("R9 change during wait not counted", int'(evt_count) - ev0, 1);
      check("R9 no push from dropped rise", rx_n, 4);
      rxd_in = 0;
      drive_bclk(0, 5, -1);
      drive_bclk(1, 5, -1);
      check("R4 receive resumes", rx_n, 5);
      check("R4 resumed bit", int'(rx_got[4]), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_not_started();
      t_rx();
      t_duplex();
      t_tx_entry();
      t_tx_bits();
      t_rx_exit();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule